// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block serves one endpoint queue. It follows a linked ring of 16-byte transfer descriptors held in system memory. Software writes descriptors, hands the engine the address of the first one and pulses start. The engine then loops through the same steps for each descriptor: it reads all four words, checks the owner bit, the skip bit and, when enabled, the byte checksum. It then either skips the descriptor or asks the data mover to transfer the described buffer. After that it writes the descriptor back with the owner bit cleared and moves on through the descriptor's link pointer.

Memory is reached through a plain one-word read/write port with an acknowledge. Packet movement itself belongs to a neighbouring block, which sees only a request/done handshake carrying the buffer address, the length and a trailing-empty-packet flag. For a receive queue, the done handshake also returns the byte count. The engine stops and goes idle when it reaches a descriptor still owned by software, or when a checksum fails. A resume pulse makes it read the same descriptor again.

Top module: `dring_qeng`

## Requirements
- R1: After reset the engine is idle (`idle_o`=1). No memory or transfer request is raised and both interrupt outputs are low.
- R2: Descriptors are 16-byte aligned. A fetch reads the words at offsets 0, 4, 8 and 12, in that order. Word 0 holds flag[7:0], checksum[15:8] and the mode field[31:16]. Word 1 is the link pointer, word 2 the buffer pointer, and word 3 holds length[15:0], extension byte[23:16] and extended flags[31:24]. A memory request keeps its address and direction stable until it is acknowledged.
- R3: A fetched descriptor with owner bit (flag bit 0) clear stops the engine. It goes idle with no transfer and no write. A resume pulse then fetches the same descriptor address again.
- R4: With checksum checking on, a descriptor is bad if the 8-bit sum of its 16 bytes differs from 0xFF. A bad owned descriptor gives a one-cycle `irq_err_o`, no transfer and no write, and the engine goes idle. Resume fetches it again.
- R5: An owned descriptor with the skip bit (flag bit 2) set causes no transfer and no write-back. The engine goes straight to the descriptor at its link pointer.
- R6: In transmit mode, the transfer address is {mode field[3:0], buffer pointer} and the length is length[15:0]. The empty-packet flag is extended-flag bit 5. The next descriptor address is {mode field[7:4], link pointer}.
- R7: In receive mode, the transfer address is {extension byte[3:0], buffer pointer} and the length is the mode field. The empty-packet flag is 0. The next descriptor address is {extension byte[7:4], link pointer}.
- R8: A transfer request keeps its address and length stable until `xfer_done_i`.
- R9: Write-back stores word 0 with only flag bit 0 cleared. In receive mode, word 3 is written first, with the returned byte count in [15:0] and the upper two bytes unchanged.
- R10: After the word-0 write is acknowledged, `irq_done_o` pulses for one cycle if and only if flag bit 7 was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load start address and begin (taken when idle) |
| start_addr_i | input | 36 | First descriptor address |
| resume_i | input | 1 | Refetch the current descriptor (taken when idle) |
| rx_mode_i | input | 1 | 1 = receive descriptor format, 0 = transmit |
| csum_en_i | input | 1 | Enable descriptor checksum check |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 36 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Data transfer request |
| xfer_addr_o | output | 36 | Buffer address |
| xfer_len_o | output | 16 | Buffer length |
| xfer_zlp_o | output | 1 | Append an empty packet |
| xfer_done_i | input | 1 | Transfer finished |
| xfer_rcvd_i | input | 16 | Bytes received (receive mode) |
| irq_done_o | output | 1 | Completion interrupt pulse |
| irq_err_o | output | 1 | Checksum error interrupt pulse |
| idle_o | output | 1 | Engine idle |

## Verification
A scoreboard compares, in order, every memory access, transfer request and interrupt against a list predicted from the descriptor contents. A transmit ring mixes descriptors with and without the completion bit and with different extension nibbles. It then wraps back onto a descriptor already handed back, which separates correct next-pointer extension from a plain link and shows that the owner stop happens. A receive run chains a normal descriptor, a skipped one and one with a corrupt checksum. This separates the receive field mapping from the transmit one, skipping from completing, and error stops from owner stops. Resume after each kind of stop confirms that the same address is fetched again and that repaired contents are then processed.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned DESC_BYTES = DESC_WORDS * 4;
  localparam int unsigned DESC_BITS  = DESC_BYTES * 8;
  localparam int unsigned FLG_OWN    = 0;
  localparam int unsigned FLG_SKIP   = 2;
  localparam int unsigned FLG_NOTIFY = 7;
  localparam int unsigned XFLG_ZLP   = 5;
  localparam logic [7:0]  CSUM_GOOD  = 8'hFF;

  // MSB first: word3, word2, word1, word0
  typedef struct packed {
    logic [7:0]  xflag;
    logic [7:0]  ext8;
    logic [15:0] len;
    logic [31:0] buf_ptr;
    logic [31:0] link_ptr;
    logic [15:0] mode16;
    logic [7:0]  csum;
    logic [7:0]  flag;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECIDE, ST_XFER, ST_WB_LEN, ST_WB_FLAG
  } st_e;
endpackage

// File: rtl/dring_csum.sv
module dring_csum #(
  parameter int unsigned NBYTES = 16
) (
  input  logic [NBYTES*8-1:0] data_i,
  output logic [7:0]          sum_o
);
  logic [7:0] acc [NBYTES+1];

  assign acc[0] = 8'h00;
  for (genvar g = 0; g < NBYTES; g++) begin : g_add
    assign acc[g+1] = acc[g] + data_i[g*8 +: 8];
  end
  assign sum_o = acc[NBYTES];
endmodule

// File: rtl/dring_decode.sv
module dring_decode
  import dring_pkg::*;
#(
  parameter int unsigned EXT_W = 4,
  localparam int unsigned ADDR_W = 32 + EXT_W
) (
  input  logic [DESC_BITS-1:0] desc_i,
  input  logic                 rx_i,
  output logic                 own_o,
  output logic                 skip_o,
  output logic                 notify_o,
  output logic                 zlp_o,
  output logic                 csum_ok_o,
  output logic [ADDR_W-1:0]    buf_addr_o,
  output logic [ADDR_W-1:0]    next_addr_o,
  output logic [15:0]          len_o
);
  desc_t      d;
  logic [7:0] ext;
  logic [7:0] sum;

  assign d = desc_t'(desc_i);

  dring_csum #(.NBYTES(DESC_BYTES)) u_csum (
    .data_i (d),
    .sum_o  (sum)
  );

  // extension nibbles live in different fields per direction
  assign ext         = rx_i ? d.ext8 : d.mode16[7:0];
  assign own_o       = d.flag[FLG_OWN];
  assign skip_o      = d.flag[FLG_SKIP];
  assign notify_o    = d.flag[FLG_NOTIFY];
  assign zlp_o       = !rx_i && d.xflag[XFLG_ZLP];
  assign csum_ok_o   = (sum == CSUM_GOOD);
  assign buf_addr_o  = {ext[EXT_W-1:0], d.buf_ptr};
  assign next_addr_o = {ext[4 +: EXT_W], d.link_ptr};
  assign len_o       = rx_i ? d.mode16 : d.len;
endmodule

// File: rtl/dring_qeng.sv
module dring_qeng
  import dring_pkg::*;
#(
  parameter int unsigned EXT_W = 4,
  localparam int unsigned ADDR_W = 32 + EXT_W,
  localparam int unsigned WIDX_W = $clog2(DESC_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              resume_i,
  input  logic              rx_mode_i,
  input  logic              csum_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [15:0]       xfer_len_o,
  output logic              xfer_zlp_o,
  input  logic              xfer_done_i,
  input  logic [15:0]       xfer_rcvd_i,
  output logic              irq_done_o,
  output logic              irq_err_o,
  output logic              idle_o
);
  st_e                  st_q;
  logic [ADDR_W-1:0]    ptr_q;
  logic [WIDX_W-1:0]    widx_q;
  logic [DESC_BITS-1:0] desc_q;
  logic [15:0]          rcvd_q;
  logic                 irq_done_q, irq_err_q;

  desc_t             dq;
  logic              own, skip, notify, csum_ok;
  logic [ADDR_W-1:0] next_addr;

  assign dq = desc_t'(desc_q);

  dring_decode #(.EXT_W(EXT_W)) u_dec (
    .desc_i      (desc_q),
    .rx_i        (rx_mode_i),
    .own_o       (own),
    .skip_o      (skip),
    .notify_o    (notify),
    .zlp_o       (xfer_zlp_o),
    .csum_ok_o   (csum_ok),
    .buf_addr_o  (xfer_addr_o),
    .next_addr_o (next_addr),
    .len_o       (xfer_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      widx_q     <= '0;
      desc_q     <= '0;
      rcvd_q     <= '0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            ptr_q  <= start_addr_i;
            widx_q <= '0;
            st_q   <= ST_FETCH;
          end else if (resume_i) begin
            widx_q <= '0;
            st_q   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack_i) begin
            desc_q[32*widx_q +: 32] <= mem_rdata_i;
            if (widx_q == WIDX_W'(DESC_WORDS - 1)) st_q <= ST_DECIDE;
            else widx_q <= widx_q + 1'b1;
          end
        end
        ST_DECIDE: begin
          if (!own) begin
            st_q <= ST_IDLE;
          end else if (csum_en_i && !csum_ok) begin
            irq_err_q <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (skip) begin
            ptr_q  <= next_addr;
            widx_q <= '0;
            st_q   <= ST_FETCH;
          end else begin
            st_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_done_i) begin
            rcvd_q <= xfer_rcvd_i;
            st_q   <= rx_mode_i ? ST_WB_LEN : ST_WB_FLAG;
          end
        end
        ST_WB_LEN: begin
          if (mem_ack_i) st_q <= ST_WB_FLAG;
        end
        ST_WB_FLAG: begin
          if (mem_ack_i) begin
            irq_done_q <= notify;
            ptr_q      <= next_addr;
            widx_q     <= '0;
            st_q       <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = ptr_q;
    mem_wdata_o = '0;
    case (st_q)
      ST_FETCH:  mem_addr_o = ptr_q + {{(ADDR_W-WIDX_W-2){1'b0}}, widx_q, 2'b00};
      ST_WB_LEN: begin
        mem_addr_o  = ptr_q + ADDR_W'(12);
        mem_wdata_o = {dq.xflag, dq.ext8, rcvd_q};
      end
      ST_WB_FLAG: mem_wdata_o = {dq.mode16, dq.csum, dq.flag & ~8'h01};
      default: ;
    endcase
  end

  assign mem_req_o  = (st_q == ST_FETCH) || (st_q == ST_WB_LEN) || (st_q == ST_WB_FLAG);
  assign mem_we_o   = (st_q == ST_WB_LEN) || (st_q == ST_WB_FLAG);
  assign xfer_req_o = (st_q == ST_XFER);
  assign irq_done_o = irq_done_q;
  assign irq_err_o  = irq_err_q;
  assign idle_o     = (st_q == ST_IDLE);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o && !xfer_req_o);
  // R1
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_req_o));
  // R2
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R8
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o));
  // R9
  own_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && (mem_addr_o[3:2] == 2'b00) |-> !mem_wdata_o[0]);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o);
  // R4
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> idle_o && !irq_done_o);
endmodule

// File: tb/tb_dring_qeng.sv
`timescale 1ns/1ps
module tb_dring_qeng;
  localparam int unsigned AW = 36;
  localparam int EV_RD = 0, EV_WR = 1, EV_XF = 2, EV_IRQ = 3, EV_ERR = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          resume_i = 1'b0;
  logic          rx_mode_i = 1'b0;
  logic          csum_en_i = 1'b0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic          mem_ack_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic          xfer_req_o;
  logic [AW-1:0] xfer_addr_o;
  logic [15:0]   xfer_len_o;
  logic          xfer_zlp_o;
  logic          xfer_done_i = 1'b0;
  logic [15:0]   xfer_rcvd_i = '0;
  logic          irq_done_o, irq_err_o, idle_o;

  always #2 clk = ~clk;

  dring_qeng dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .resume_i(resume_i), .rx_mode_i(rx_mode_i), .csum_en_i(csum_en_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
    .xfer_zlp_o(xfer_zlp_o), .xfer_done_i(xfer_done_i), .xfer_rcvd_i(xfer_rcvd_i),
    .irq_done_o(irq_done_o), .irq_err_o(irq_err_o), .idle_o(idle_o)
  );

  typedef struct {
    int            kind;
    logic [AW-1:0] a;
    logic [31:0]   b;
    string         tag;
  } ev_t;

  ev_t         exp_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] mem [0:255];
  int          mwait = 0, mlat = 0, xwait = 0, xlat = 1;
  logic [15:0] rx_cnt_v = '0;

  task automatic push(input int kind, input logic [AW-1:0] a, input logic [31:0] b, input string tag);
    ev_t e;
    e.kind = kind; e.a = a; e.b = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic exp_fetch(input logic [AW-1:0] a, input string tag);
    for (int i = 0; i < 4; i++) push(EV_RD, a + AW'(4*i), 32'h0, tag);
  endtask

  task automatic got(input int kind, input logic [AW-1:0] a, input logic [31:0] b);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R3 R5 unexpected activity actual kind=%0d a=%h b=%h expected none", kind, a, b);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.a != a || e.b != b) begin
        errors++;
        $display("FAIL %s actual kind=%0d a=%h b=%h expected kind=%0d a=%h b=%h",
                 e.tag, kind, a, b, e.kind, e.a, e.b);
      end
    end
  endtask

  // scoreboard monitor and memory / data-mover responders
  always @(negedge clk) begin
    if (rst_ni) begin
      if (irq_done_o) got(EV_IRQ, '0, 32'h0);
      if (irq_err_o)  got(EV_ERR, '0, 32'h0);
      if (xfer_done_i) begin
        xfer_done_i = 1'b0; xwait = xlat; xlat ^= 1;
      end else if (xfer_req_o) begin
        if (xwait == 0) begin
          xfer_done_i = 1'b1;
          xfer_rcvd_i = rx_cnt_v;
          got(EV_XF, xfer_addr_o, {15'd0, xfer_zlp_o, xfer_len_o});
        end else xwait--;
      end
      if (mem_ack_i) begin
        mem_ack_i = 1'b0; mwait = mlat; mlat ^= 1;
      end else if (mem_req_o) begin
        if (mwait == 0) begin
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            mem[mem_addr_o[9:2]] = mem_wdata_o;
            got(EV_WR, mem_addr_o, mem_wdata_o);
          end else begin
            mem_rdata_i = mem[mem_addr_o[9:2]];
            got(EV_RD, mem_addr_o, 32'h0);
          end
        end else mwait--;
      end
    end
  end

  task automatic put_desc(input logic [AW-1:0] a, input logic [7:0] flag, input logic [15:0] m16,
                          input logic [31:0] link, input logic [31:0] bptr, input logic [15:0] len,
                          input logic [7:0] ext8, input logic [7:0] xflag, input bit good,
                          output logic [7:0] c);
    logic [7:0] s;
    s = flag + m16[7:0] + m16[15:8] + link[7:0] + link[15:8] + link[23:16] + link[31:24]
      + bptr[7:0] + bptr[15:8] + bptr[23:16] + bptr[31:24] + len[7:0] + len[15:8] + ext8 + xflag;
    c = 8'hFF - s;
    if (!good) c = c + 8'h01;
    mem[a[9:2]]     = {m16, c, flag};
    mem[a[9:2] + 1] = link;
    mem[a[9:2] + 2] = bptr;
    mem[a[9:2] + 3] = {xflag, ext8, len};
  endtask

  task automatic kick(input logic [AW-1:0] a);
    @(negedge clk); start_i = 1'b1; start_addr_i = a;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_resume();
    @(negedge clk); resume_i = 1'b1;
    @(negedge clk); resume_i = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int quiet = 0;
    for (int i = 0; i < 4000 && quiet < 6; i++) begin
      @(negedge clk);
      if (idle_o && exp_q.size() == 0) quiet++; else quiet = 0;
    end
    checks++;
    if (quiet < 6) begin
      errors++;
      $display("FAIL %s actual idle=%0b pending=%0d expected idle=1 pending=0", tag, idle_o, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic chk1(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] c0, c1, c2, c3, c4, c5;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk1(idle_o, 1'b1, "R1 idle");
    chk1(mem_req_o, 1'b0, "R1 mem_req");
    chk1(xfer_req_o, 1'b0, "R1 xfer_req");
    chk1(irq_done_o | irq_err_o, 1'b0, "R1 irq");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk1(idle_o, 1'b1, "R1 idle after release");

    // transmit ring: notify / no notify, extension nibbles, wrap onto returned descriptor
    rx_mode_i = 1'b0; csum_en_i = 1'b0;
    put_desc(36'h040, 8'h81, 16'h0003, 32'h060, 32'h1234_5670, 16'd100, 8'h00, 8'h20, 1'b1, c0);
    put_desc(36'h060, 8'h01, 16'h0050, 32'h040, 32'h0000_2000, 16'd8, 8'hAB, 8'h00, 1'b1, c1);
    exp_fetch(36'h040, "R2");
    push(EV_XF, {4'h3, 32'h1234_5670}, {15'd0, 1'b1, 16'd100}, "R6 R8 tx mapping");
    push(EV_WR, 36'h040, {16'h0003, c0, 8'h80}, "R9 tx word0");
    push(EV_IRQ, '0, 32'h0, "R10 notify");
    exp_fetch(36'h060, "R6 next pointer");
    push(EV_XF, 36'h0_0000_2000, {15'd0, 1'b0, 16'd8}, "R6 R8 no zlp");
    push(EV_WR, 36'h060, {16'h0050, c1, 8'h00}, "R9 tx word0 no notify");
    exp_fetch(36'h5_0000_0040, "R6 next extension");
    kick(36'h040);
    wait_idle("R3 owner stop");

    // resume refetches the stopped descriptor
    put_desc(36'h040, 8'h01, 16'h0000, 32'h0A0, 32'h0000_0300, 16'd4, 8'h00, 8'h00, 1'b1, c2);
    put_desc(36'h0A0, 8'h00, 16'h0000, 32'h040, 32'h0, 16'd0, 8'h00, 8'h00, 1'b1, c3);
    exp_fetch(36'h5_0000_0040, "R3 resume address");
    push(EV_XF, 36'h0_0000_0300, {15'd0, 1'b0, 16'd4}, "R6 R8");
    push(EV_WR, 36'h5_0000_0040, {16'h0000, c2, 8'h00}, "R9");
    exp_fetch(36'h0A0, "R3");
    do_resume();
    wait_idle("R3 second stop");

    // receive ring with checksum: normal, skipped, corrupt
    rx_mode_i = 1'b1; csum_en_i = 1'b1; rx_cnt_v = 16'd37;
    put_desc(36'h100, 8'h81, 16'h0040, 32'h120, 32'h0000_8000, 16'd0, 8'h21, 8'h20, 1'b1, c4);
    put_desc(36'h120, 8'h05, 16'h0099, 32'h140, 32'h0000_5000, 16'd2, 8'h00, 8'h00, 1'b1, c3);
    put_desc(36'h140, 8'h81, 16'h0010, 32'h160, 32'h0000_9000, 16'd0, 8'h00, 8'h00, 1'b0, c5);
    exp_fetch(36'h100, "R2");
    push(EV_XF, {4'h1, 32'h0000_8000}, {15'd0, 1'b0, 16'd64}, "R7 R8 rx mapping");
    push(EV_WR, 36'h10C, {8'h20, 8'h21, 16'd37}, "R9 rx count");
    push(EV_WR, 36'h100, {16'h0040, c4, 8'h80}, "R9 rx word0");
    push(EV_IRQ, '0, 32'h0, "R10");
    exp_fetch(36'h2_0000_0120, "R7 next extension");
    exp_fetch(36'h140, "R5 skip");
    push(EV_ERR, '0, 32'h0, "R4 checksum error");
    kick(36'h100);
    wait_idle("R4 error stop");
    // R5: skipped descriptor left untouched in memory
    checks++;
    if (mem[8'h48] !== {16'h0099, c3, 8'h05}) begin
      errors++;
      $display("FAIL R5 skipped word0 actual=%h expected=%h", mem[8'h48], {16'h0099, c3, 8'h05});
    end

    // repair and resume
    rx_cnt_v = 16'd12;
    put_desc(36'h140, 8'h81, 16'h0010, 32'h160, 32'h0000_9000, 16'd0, 8'h00, 8'h00, 1'b1, c5);
    put_desc(36'h160, 8'h00, 16'h0000, 32'h100, 32'h0, 16'd0, 8'h00, 8'h00, 1'b1, c3);
    exp_fetch(36'h140, "R4 resume after error");
    push(EV_XF, 36'h0_0000_9000, {15'd0, 1'b0, 16'd16}, "R7 R8");
    push(EV_WR, 36'h14C, {8'h00, 8'h00, 16'd12}, "R9");
    push(EV_WR, 36'h140, {16'h0010, c5, 8'h80}, "R9");
    push(EV_IRQ, '0, 32'h0, "R10");
    exp_fetch(36'h160, "R3");
    do_resume();
    wait_idle("R3 final stop");
    chk1(irq_err_o | irq_done_o, 1'b0, "R10 quiet when idle");

    finish_run();
  end
endmodule